// File: doc/BRIEF.md
# Sleep-Domain Wakeup Interrupt Monitor

This block sits in the always-on power domain. It watches a configurable set of interrupt pins (96 by default) while the rest of the system is powered down. Each pin can be armed for a rising edge, a falling edge or an active-high level. When an armed and enabled pin fires during sleep, the block latches a status bit and raises a wake request. Host software sets up the per-pin controls through a 32-bit register bank and clears every status word. It then pulses a sleep request, which hands ownership of the configuration to the sleep side. Once the host is running again, the power sequencer pulses a wake-done input. Ownership then returns to the host, and a one-cycle resume interrupt tells software to read status masked by enable and replay the pending pins.

The register bank is split into five groups: enable, falling-edge arm, rising-edge arm, level polarity and status. Each group holds one word per 32 pins. Two general storage words come before all the groups. Pin p always occupies bit p mod 32 of word p/32 within a group.

Top module: `wake_irq_monitor`

## Requirements
- R1: Word k (k from 0 to 2) of group g sits at byte address (g*W + k + 2)*4, where W = ceil(NPINS/32) and the groups are numbered enable=0, falling=1, rising=2, polarity=3, status=4. Two plain storage words at byte addresses 0x00 and 0x04 read back whatever was last written to them.
- R2: Pin p maps to bit p%32 of word p/32 in every group. Bits for pins at or above NPINS always read as zero. Any address beyond the last status word reads as zero.
- R3: A one-cycle pulse on sleep_req moves the block from awake to asleep. A one-cycle pulse on wake_done while asleep returns it to awake, and resume_irq is high for exactly the one cycle after that edge.
- R4: A host write that arrives while asleep changes no register and sets err_flag. err_flag stays set until the next accepted sleep_req clears it.
- R5: Every pin passes through a two-flop synchroniser. A low-to-high change on a pin whose rising bit and enable bit are both set sets its status bit while asleep.
- R6: A high-to-low change on a pin whose falling bit and enable bit are both set sets its status bit while asleep.
- R7: A pin whose polarity bit and enable bit are both set and whose input is high sets its status bit while asleep, including when the pin is already high at sleep entry.
- R8: Status never sets for a pin whose enable bit is clear, and never sets while the block is awake.
- R9: Status bits are sticky. A host write to a status word clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R10: wake_out is high exactly when the block is asleep and some pin has both its status bit and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pins | input | NPINS | Asynchronous wakeup pins |
| sleep_req | input | 1 | Sleep-entry handshake pulse from host |
| wake_done | input | 1 | Host-operational pulse from power sequencer |
| wake_out | output | 1 | Wake request to the power sequencer |
| resume_irq | output | 1 | One-cycle resume interrupt to host |
| err_flag | output | 1 | Host wrote while the sleep side owned the bank |

## Verification
The assertions take for granted that sleep_req and wake_done are single-cycle pulses that never arrive together. They also assume that a pin held stable for three cycles has passed through the synchroniser. The stimulus therefore holds every pin pattern for four or more cycles, so each event is seen exactly once. It pulses the handshake inputs one at a time, at the falling clock edge. The random phase draws enable, arming and pin patterns from a seeded generator. A bench model then works out the expected status from the sequence of pin patterns.

// File: rtl/wake_irq_monitor.sv
module wake_irq_monitor #(
  parameter int NPINS = 96,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pins,
  input  logic             sleep_req,
  input  logic             wake_done,
  output logic             wake_out,
  output logic             resume_irq,
  output logic             err_flag
);
  localparam int WPG   = (NPINS + 31) / 32;
  localparam int PADW  = WPG * 32;
  localparam int NWORD = 2 + 5 * WPG;
  localparam logic [PADW-1:0] VALID = {PADW{1'b1}} >> (PADW - NPINS);

  logic [31:0]      tmr0, tmr1;
  logic [PADW-1:0]  en_r, fe_r, re_r, pol_r, st_r, st_nx;
  logic [NPINS-1:0] s1, s2, prev;
  logic [PADW-1:0]  cur_p, prv_p, evt;
  logic             asleep, wr_ok;
  int               word, grp, idx;

  assign word  = int'(bus_addr[AW-1:2]);
  assign grp   = (word >= 2) ? (word - 2) / WPG : 0;
  assign idx   = (word >= 2) ? (word - 2) % WPG : 0;
  assign wr_ok = bus_wr && !asleep;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prev <= '0;
    end else begin
      s1 <= pins; s2 <= s1; prev <= s2;
    end

  always_comb begin
    cur_p = '0; prv_p = '0;
    cur_p[NPINS-1:0] = s2;
    prv_p[NPINS-1:0] = prev;
    evt = en_r & VALID & ((re_r & cur_p & ~prv_p) |
                          (fe_r & ~cur_p & prv_p) |
                          (pol_r & cur_p));
  end

  always_comb begin
    st_nx = st_r | (asleep ? evt : '0);
    if (wr_ok && word >= 2 && word < NWORD && grp == 4)
      st_nx[idx*32 +: 32] = st_nx[idx*32 +: 32] & bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmr0 <= '0; tmr1 <= '0;
      en_r <= '0; fe_r <= '0; re_r <= '0; pol_r <= '0; st_r <= '0;
    end else begin
      st_r <= st_nx;
      if (wr_ok) begin
        if (word == 0) tmr0 <= bus_wdata;
        if (word == 1) tmr1 <= bus_wdata;
        if (word >= 2 && word < NWORD)
          case (grp)
            0: en_r[idx*32 +: 32]  <= bus_wdata & VALID[idx*32 +: 32];
            1: fe_r[idx*32 +: 32]  <= bus_wdata & VALID[idx*32 +: 32];
            2: re_r[idx*32 +: 32]  <= bus_wdata & VALID[idx*32 +: 32];
            3: pol_r[idx*32 +: 32] <= bus_wdata & VALID[idx*32 +: 32];
            default: ;
          endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      asleep <= 1'b0; resume_irq <= 1'b0; err_flag <= 1'b0;
    end else begin
      resume_irq <= asleep && wake_done;
      if (!asleep && sleep_req) begin
        asleep   <= 1'b1;
        err_flag <= 1'b0;
      end else if (asleep && wake_done) begin
        asleep <= 1'b0;
      end
      if (bus_wr && asleep) err_flag <= 1'b1;
    end

  always_comb begin
    bus_rdata = '0;
    if (word == 0) bus_rdata = tmr0;
    else if (word == 1) bus_rdata = tmr1;
    else if (word < NWORD)
      case (grp)
        0: bus_rdata = en_r[idx*32 +: 32];
        1: bus_rdata = fe_r[idx*32 +: 32];
        2: bus_rdata = re_r[idx*32 +: 32];
        3: bus_rdata = pol_r[idx*32 +: 32];
        default: bus_rdata = st_r[idx*32 +: 32] & VALID[idx*32 +: 32];
      endcase
  end

  assign wake_out = asleep && |(st_r & en_r);

  AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resume_irq |=> !resume_irq); // R3
  AST_RESUME_AFTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_irq) |-> !asleep && $past(asleep)); // R3
  AST_WRITE_WHILE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && asleep) |=> err_flag); // R4
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && asleep) |=> $stable(en_r) && $stable(pol_r)); // R4
  AST_NO_SET_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(asleep) |-> (st_r & ~$past(st_r)) == '0); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_ok) |-> (st_r & $past(st_r)) == $past(st_r)); // R9
  AST_NO_WAKE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !asleep |-> !wake_out); // R10
endmodule

// File: tb/wake_irq_monitor_bench.sv
module wake_irq_monitor_bench;
  localparam int NP = 70;
  localparam int AW = 8;
  logic clk = 0, rst_n = 0, bus_wr = 0, sleep_req = 0, wake_done = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pins = '0;
  logic wake_out, resume_irq, err_flag;
  int checks = 0, failures = 0;
  bit done = 0;

  wake_irq_monitor #(.NPINS(NP), .AW(AW)) u_wake_irq_monitor (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .pins,
    .sleep_req, .wake_done, .wake_out, .resume_irq, .err_flag);

  always #5 clk = ~clk;

  function automatic logic [AW-1:0] ga(int g, int k);
    return AW'((g * 3 + k + 2) * 4);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_sleep();
    @(negedge clk); sleep_req = 1; @(negedge clk); sleep_req = 0;
  endtask

  task automatic go_wake(bit chk_pulse);
    @(negedge clk); wake_done = 1;
    @(negedge clk); wake_done = 0;
    if (chk_pulse) chk("R3 resume pulse", 32'(resume_irq), 1);
    @(negedge clk);
    if (chk_pulse) chk("R3 resume single", 32'(resume_irq), 0);
  endtask

  task automatic clear_status();
    for (int k = 0; k < 3; k++) wr(ga(4, k), 32'h0);
  endtask

  function automatic logic [NP-1:0] rnd_pins();
    return NP'({$urandom, $urandom, $urandom});
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    idle(3); rst_n = 1; idle(1);

    rd(ga(0, 0), d); chk("R1 reset enable", d, 0);
    chk("R10 reset wake", 32'(wake_out), 0);
    chk("R4 reset err", 32'(err_flag), 0);

    wr(8'h00, 32'hCAFE0001); wr(8'h04, 32'h1234ABCD);
    rd(8'h00, d); chk("R1 storage word0", d, 32'hCAFE0001);
    rd(8'h04, d); chk("R1 storage word1", d, 32'h1234ABCD);
    wr(8'h0C, 32'h00A5_5A00); rd(8'h0C, d); chk("R1 enable word1 @0x0C", d, 32'h00A5_5A00);
    wr(8'h2C, 32'h8000_0001); rd(8'h2C, d); chk("R1 polarity word0 @0x2C", d, 32'h8000_0001);
    wr(ga(0, 2), 32'hFFFF_FFFF); rd(ga(0, 2), d); chk("R2 partial word pad", d, 32'h3F);
    rd(8'h44, d); chk("R2 unmapped read", d, 0);
    for (int g = 0; g < 4; g++) for (int k = 0; k < 3; k++) wr(ga(g, k), 0);

    wr(ga(0, 0), 32'h20); wr(ga(2, 0), 32'h20);
    pins[5] = 1; idle(4); pins[5] = 0; idle(4);
    rd(ga(4, 0), d); chk("R8 no status awake", d, 0);

    go_sleep(); idle(4);
    chk("R10 quiet sleep", 32'(wake_out), 0);
    pins[5] = 1; idle(4);
    chk("R10 wake on rise", 32'(wake_out), 1);
    go_wake(1);
    rd(ga(4, 0), d); chk("R5 rising status", d, 32'h20);
    wr(ga(4, 0), 32'hFFFF_FFFF); rd(ga(4, 0), d); chk("R9 write one keeps", d, 32'h20);
    wr(ga(4, 0), 32'hFFFF_FFDF); rd(ga(4, 0), d); chk("R9 write zero clears", d, 0);

    go_sleep(); wr(ga(0, 1), 32'hFFFF);
    chk("R4 err set", 32'(err_flag), 1);
    go_wake(0);
    rd(ga(0, 1), d); chk("R4 write ignored", d, 0);
    chk("R4 err sticky", 32'(err_flag), 1);

    wr(ga(0, 1), 32'h3); wr(ga(1, 1), 32'h1); wr(ga(3, 1), 32'h2);
    wr(ga(2, 2), 32'h1);
    pins[32] = 1; pins[33] = 1; idle(4);
    go_sleep(); idle(1);
    chk("R4 err cleared", 32'(err_flag), 0);
    idle(3);
    rd(ga(4, 1), d); chk("R7 level at entry", d, 32'h2);
    pins[32] = 0; pins[64] = 1; idle(4);
    go_wake(1);
    rd(ga(4, 1), d); chk("R6 falling status", d, 32'h3);
    rd(ga(4, 2), d); chk("R8 disabled pin no status", d, 0);
    pins = '0; idle(4);

    for (int it = 0; it < 20; it++) begin
      logic [NP-1:0] en, fe, re, pl, cur, nxt, ex;
      logic [95:0] wide;
      en = rnd_pins(); fe = rnd_pins(); re = rnd_pins(); pl = rnd_pins() & rnd_pins();
      clear_status();
      for (int k = 0; k < 3; k++) begin
        wide = 96'(en); wr(ga(0, k), wide[k*32 +: 32]);
        wide = 96'(fe); wr(ga(1, k), wide[k*32 +: 32]);
        wide = 96'(re); wr(ga(2, k), wide[k*32 +: 32]);
        wide = 96'(pl); wr(ga(3, k), wide[k*32 +: 32]);
      end
      cur = rnd_pins(); pins = cur; idle(4);
      go_sleep(); idle(4);
      ex = en & pl & cur;
      for (int s = 0; s < 6; s++) begin
        nxt = rnd_pins() & rnd_pins();
        pins = nxt; idle(4);
        ex |= en & ((re & ~cur & nxt) | (fe & cur & ~nxt) | (pl & nxt));
        cur = nxt;
      end
      chk("R10 random wake", 32'(wake_out), 32'(|ex));
      go_wake(0);
      wide = 96'(ex);
      for (int k = 0; k < 3; k++) begin
        rd(ga(4, k), d);
        chk("R5 R6 R7 random status", d, wide[k*32 +: 32]);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule